// File: doc/BRIEF.md
# Four-Class Preemptive Flit Scheduler

This block is the output-port scheduler of an on-chip network switch whose single outgoing link is shared by four service classes. Each class arrives on its own flit stream and is held in a small per-class buffer. Every cycle the scheduler forwards at most one flit. It takes the most urgent class that both holds a flit and has a downstream credit. A packet of a lower class can therefore be interrupted between any two of its flits by a more urgent class, and it continues from its next flit once nothing more urgent is eligible.

Downstream buffer space is tracked with one credit counter per class. A credit is spent when a flit of that class leaves, and it is restored when the receiver pulses that class's return line. Each outgoing flit carries a 2-bit class code so the receiver can steer it into the matching buffer.

Top module: `qos_link_sched`

## Requirements
- R1: While reset is held low at a clock edge, the output valid goes low, every input ready goes high (all buffers empty), and every class credit returns to its full value CRED_MAX.
- R2: A class's input ready is low exactly when its buffer holds BUF_DEPTH flits. A flit offered while ready is low is not stored and never appears at the output.
- R3: At most one flit leaves per cycle. Among the eligible classes (buffer not empty and credit above zero), the class with the lowest code wins. Codes are 0 = signaling (most urgent), 1 = real-time, 2 = read/write, 3 = block-transfer (least urgent).
- R4: A class whose credit is zero is skipped even when it is the most urgent class holding a flit, and a less urgent eligible class is sent instead.
- R5: The output class field carries the 2-bit code of the class the flit was taken from, and the output data equals that flit unchanged.
- R6: Flits of one class leave in the order they were accepted, including across preemption by a more urgent class.
- R7: Each flit sent lowers its class's credit by one, and each return pulse raises it by one, so the flits of a class that are sent but not yet returned never exceed CRED_MAX.
- R8: A flit accepted at a clock edge into an empty, idle system appears at the output one clock edge later, with the output valid after that second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 4 | Per-class flit offered, bit = class code |
| in_data | input | 4*FLIT_W | Per-class flit, class c at bits [c*FLIT_W +: FLIT_W] |
| in_ready | output | 4 | Per-class buffer has room |
| cred_ret | input | 4 | Per-class credit return pulse, one credit per cycle high |
| out_valid | output | 1 | Output flit present this cycle |
| out_cls | output | 2 | Class code of the output flit |
| out_data | output | FLIT_W | Output flit |

## Verification
The first pattern is a single flit sent into an idle block, which shows the two-edge latency and the class field. A run with the signaling credit exhausted while its buffer is full shows that an out-of-credit class is skipped in favour of read/write traffic. A long block-transfer stream broken into by a signaling burst shows preemption in the middle of a packet and the resumption in order afterwards. A random phase with all classes, random offers and random credit returns checks every cycle against a queue-based model, which covers the priority, full-buffer, order and credit rules under contention.

// File: rtl/qos_sched_pkg.sv
// Shared constants for the four-class link scheduler.
// Assumes exactly four service classes encoded in two bits.
package qos_sched_pkg;
    localparam int NUM_CLS = 4;
    localparam int CLS_W   = 2;
    typedef logic [CLS_W-1:0] cls_t;
endpackage

// File: rtl/qos_class_fifo.sv
// Per-class flit buffer: a small circular store with push on accept and pop on grant.
// Assumes the caller pops only when non-empty; a push while full is refused through rdy.
module qos_class_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    output logic         rdy,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push;

    assign rdy       = (count != CW'(DEPTH));
    assign push      = push_req && rdy;
    assign not_empty = (count != '0);
    assign head      = mem[rd_ptr];

    // Store an accepted flit at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !pop) |=> !rdy);
endmodule

// File: rtl/qos_credit_ctr.sv
// Per-class downstream credit counter: spend on send, restore on return pulse.
// Assumes the receiver never returns more credits than were spent.
module qos_credit_ctr #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spend,
    input  logic give,
    output logic has_credit
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt;

    assign has_credit = (cnt != '0);

    // Track free downstream slots for this class.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= CW'(MAX);
        else        cnt <= cnt - CW'(spend) + CW'(give);
    end

    a_r7_no_spend_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        spend |-> has_credit);
    a_r7_cred_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX));
    a_r7_spend_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (spend && !give) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/qos_prio_pick.sv
// Fixed-priority picker: lowest index among eligible requests wins, plus its code.
// Assumes index 0 is the most urgent class.
module qos_prio_pick
    import qos_sched_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLS-1:0] elig,
    output logic [NUM_CLS-1:0] grant,
    output cls_t               code
);
    logic [NUM_CLS:0] above;

    assign above[0] = 1'b0;
    for (genvar i = 0; i < NUM_CLS; i++) begin : g_chain
        assign grant[i]   = elig[i] && !above[i];
        assign above[i+1] = above[i] || elig[i];
    end

    // Encode the granted index into the class code.
    always_comb begin
        code = '0;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (grant[i]) code = cls_t'(i);
        end
    end

    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r3_grant_if_any: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> (grant != '0));
    a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        elig[0] |-> grant[0]);
endmodule

// File: rtl/qos_link_sched.sv
// Output-port scheduler for a four-class link: per-class buffers and credits,
// strict class priority per flit, registered output with class code.
// Assumes credit returns never exceed flits sent per class.
module qos_link_sched
    import qos_sched_pkg::*;
#(
    parameter int FLIT_W    = 8,
    parameter int BUF_DEPTH = 4,
    parameter int CRED_MAX  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CLS-1:0]        in_valid,
    input  logic [NUM_CLS*FLIT_W-1:0] in_data,
    output logic [NUM_CLS-1:0]        in_ready,
    input  logic [NUM_CLS-1:0]        cred_ret,
    output logic                      out_valid,
    output logic [CLS_W-1:0]          out_cls,
    output logic [FLIT_W-1:0]         out_data
);
    logic [NUM_CLS-1:0] not_empty, has_cred, elig, grant;
    logic [FLIT_W-1:0]  head [NUM_CLS];
    logic [FLIT_W-1:0]  sel_data;
    cls_t               sel_code;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        qos_class_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_req  (in_valid[c]),
            .push_data (in_data[c*FLIT_W +: FLIT_W]),
            .rdy       (in_ready[c]),
            .pop       (grant[c]),
            .head      (head[c]),
            .not_empty (not_empty[c])
        );
        qos_credit_ctr #(.MAX(CRED_MAX)) u_cred (
            .clk        (clk),
            .rst_n      (rst_n),
            .spend      (grant[c]),
            .give       (cred_ret[c]),
            .has_credit (has_cred[c])
        );
    end

    assign elig = not_empty & has_cred;

    qos_prio_pick u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .grant (grant),
        .code  (sel_code)
    );

    assign sel_data = head[sel_code];

    // Register the chosen flit and its class onto the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_cls   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= |grant;
            out_cls   <= sel_code;
            out_data  <= sel_data;
        end
    end

    a_r4_skip_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty[0] && !has_cred[0]) |-> !grant[0]);
    a_r3_send_when_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |=> out_valid);
    a_r8_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty == '0) |=> !out_valid);
endmodule

// File: tb/tb_qos_link_sched.sv
module tb_qos_link_sched;
    localparam int NC = 4;
    localparam int W  = 8;
    localparam int D  = 4;
    localparam int CM = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   in_valid = '0;
    logic [NC*W-1:0] in_data = '0;
    logic [NC-1:0]   in_ready;
    logic [NC-1:0]   cred_ret = '0;
    logic            out_valid;
    logic [1:0]      out_cls;
    logic [W-1:0]    out_data;

    qos_link_sched #(.FLIT_W(W), .BUF_DEPTH(D), .CRED_MAX(CM)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cred_ret(cred_ret), .out_valid(out_valid),
        .out_cls(out_cls), .out_data(out_data)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit skip_seen = 1'b0;

    // Behavioural model state
    logic [W-1:0] mq [NC][$];
    int  mc [NC];
    int  gen_seq [NC];
    int  rx_seq [NC];
    int  outst [NC];
    bit  exp_v;
    int  exp_cls;
    logic [W-1:0] exp_d;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advance at each edge from pre-edge state
    always @(posedge clk) begin
        int pick;
        int sz [NC];
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                mq[c].delete(); mc[c] = CM; gen_seq[c] = 0; rx_seq[c] = 0; outst[c] = 0;
            end
            exp_v = 1'b0;
        end else begin
            for (int c = 0; c < NC; c++) sz[c] = mq[c].size();
            pick = -1;
            for (int c = 0; c < NC; c++)
                if (pick < 0 && sz[c] > 0 && mc[c] > 0) pick = c;
            exp_v = (pick >= 0);
            if (exp_v) begin
                exp_cls = pick;
                exp_d = mq[pick].pop_front();
                mc[pick]--;
                outst[pick]++;
            end
            for (int c = 0; c < NC; c++) begin
                if (in_valid[c] && sz[c] < D) begin
                    mq[c].push_back(in_data[c*W +: W]);
                    gen_seq[c]++;
                end
                if (cred_ret[c]) begin
                    mc[c]++;
                    outst[c]--;
                end
            end
        end
    end

    // Compare DUT against model away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            for (int c = 0; c < NC; c++)
                chk(in_ready[c] == (mq[c].size() < D), "R2 in_ready", int'(in_ready[c]),
                    int'(mq[c].size() < D));
            chk(out_valid == exp_v, "R3 out_valid", int'(out_valid), int'(exp_v));
            if (out_valid && exp_v) begin
                chk(int'(out_cls) == exp_cls, "R5 out_cls", int'(out_cls), exp_cls);
                chk(out_data == exp_d, "R5 out_data", int'(out_data), int'(exp_d));
                chk(int'(out_data[5:0]) == (rx_seq[out_cls] & 63), "R6 order",
                    int'(out_data[5:0]), rx_seq[out_cls] & 63);
                chk(int'(out_data[7:6]) == int'(out_cls), "R5 tag", int'(out_data[7:6]),
                    int'(out_cls));
                rx_seq[out_cls]++;
                chk(outst[out_cls] <= CM, "R7 outstanding", outst[out_cls], CM);
                if (out_cls == 2'd2 && mq[0].size() > 0 && mc[0] == 0) skip_seen = 1'b1;
            end
        end
    end

    // Drive one cycle of inputs at the falling edge
    task automatic cyc(input logic [NC-1:0] vm, input logic [NC-1:0] rm, input bit rnd);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            in_valid[c] = vm[c] && (!rnd || ($urandom % 2 == 0));
            in_data[c*W +: W] = {2'(c), 6'(gen_seq[c])};
            cred_ret[c] = rm[c] && (outst[c] > 0) && (!rnd || ($urandom % 3 != 0));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 4'hF, "R1 in_ready", int'(in_ready), 15);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R8: single flit latency
        cyc(4'b0010, 4'b0000, 1'b0);
        cyc(4'b0000, 4'b0000, 1'b0);
        chk(out_valid == 1'b0, "R8 not yet", int'(out_valid), 0);
        cyc(4'b0000, 4'b0000, 1'b0);
        chk(out_valid == 1'b1 && out_cls == 2'd1, "R8 arrives", int'(out_cls), 1);
        repeat (4) cyc(4'b0000, 4'b0010, 1'b0);

        // R1: full credits after reset - four signaling flits go back to back
        repeat (10) cyc(4'b0001, 4'b0000, 1'b0);
        // R4: signaling out of credit and buffer full, read/write must pass
        repeat (12) cyc(4'b0101, 4'b0100, 1'b0);
        chk(skip_seen, "R4 skip", int'(skip_seen), 1);
        chk(in_ready[0] == 1'b0, "R2 full", int'(in_ready[0]), 0);
        repeat (20) cyc(4'b0000, 4'b1111, 1'b0);

        // R6: block-transfer stream preempted by signaling burst
        repeat (10) cyc(4'b1000, 4'b1111, 1'b0);
        repeat (6)  cyc(4'b1001, 4'b1111, 1'b0);
        repeat (10) cyc(4'b1000, 4'b1111, 1'b0);
        repeat (20) cyc(4'b0000, 4'b1111, 1'b0);

        // R3 R7: random mixed traffic
        repeat (4000) cyc(4'b1111, 4'b1111, 1'b1);
        repeat (60) cyc(4'b0000, 4'b1111, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule